// File: doc/BRIEF.md
# Shortened Reed-Solomon Outer Encoder

This block is the outer error-protection stage of a broadcast channel-coding chain. It takes a byte stream of 188-byte transport packets, each marked by a start strobe, and forms a systematic codeword from each one. The 188 information bytes pass through untouched. On the next 16 accepted cycles the block emits 16 check bytes, which gives 204 bytes per packet. The code is a shortened form of a 255-symbol code over a 256-element Galois field. Leading zero symbols never change the remainder, so the shortening costs no logic.

The check bytes are the remainder of the message polynomial, scaled by x^16, after division by a degree-16 generator. A chain of 16 byte registers performs that division with feedback. The generator has roots α^±1 through α^±8, a set that is closed under inversion. Its coefficients are therefore palindromic, so each mirrored pair of taps uses a single constant multiplier. The upstream source supplies one valid strobe for every output slot, and that includes the 16 parity slots. Every accepted input produces exactly one registered output byte one cycle later.

Top module: `rs_outer_enc`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, out_sop and out_par are low.
- R2: Packet bytes 0..187 appear on out_byte unchanged, one cycle after they are accepted, with out_par low.
- R3: The 16 valid cycles after byte 187 each emit one parity byte with out_par high, so every packet gives 204 output bytes.
- R4: The field uses x^8+x^4+x^3+x^2+1 (0x11D) with α=0x02. For the output bytes c_0..c_203 in output order, c(x)=Σ c_j·x^(203−j) evaluates to zero at α^k for k = 1..8 and at α^(255−k) for k = 1..8. The first parity byte is the highest-order remainder term.
- R5: A packet of 188 zero bytes yields 16 zero parity bytes.
- R6: out_sop is high exactly on byte 0 of each codeword.
- R7: A cycle with in_valid low produces out_valid low on the next cycle and does not advance the codeword.
- R8: in_sop with in_valid, seen in either the data phase or the parity phase, abandons the open codeword. The new codeword starts from cleared parity and is correct by R4.
- R9: With no codeword open, a valid byte without in_sop is ignored and out_valid stays low.
- R10: in_byte is ignored during the 16 parity slots and has no effect on the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input slot strobe |
| in_sop | input | 1 | First byte of a packet |
| in_byte | input | 8 | Input data byte |
| out_valid | output | 1 | Output byte strobe |
| out_sop | output | 1 | First byte of a codeword |
| out_par | output | 1 | Output byte is a parity byte |
| out_byte | output | 8 | Output data or parity byte |

## Verification
Each codeword is checked by evaluating the codeword polynomial at all 16 generator roots. A wrong tap coefficient, a misplaced shared multiplier or a reversed parity order leaves a non-zero syndrome. Packets with a single non-zero byte at the first, second, middle and last positions isolate individual tap errors. A failure to mask the feedback shows up when junk is driven during the parity slots. A design that does not clear on a restart shows up when packets are aborted in the data phase and in the parity phase, because stale remainder then leaks into the next codeword. Gaps in the valid strobe and valid bytes sent outside any packet catch a counter that advances on empty or stray cycles.

// File: rtl/rs_pkg.sv
// Shared Galois-field helpers and code sizes for the outer encoder.
// Assumes field polynomial x^8+x^4+x^3+x^2+1 and primitive element 0x02.
package rs_pkg;
    localparam int RS_K    = 188;
    localparam int RS_NPAR = 16;

    // Multiply two field elements (shift-and-add with reduction).
    function automatic logic [7:0] rs_gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1D : 8'h00);
        end
        return acc;
    endfunction

    // Primitive element raised to a non-negative power.
    function automatic logic [7:0] rs_gf_pow(input int e);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 0; i < (e % 255); i++) r = rs_gf_mul(r, 8'h02);
        return r;
    endfunction

    // Coefficient idx of the monic generator with roots a^+-1..a^+-(npar/2).
    function automatic logic [7:0] rs_gen_coef(input int npar, input int idx);
        logic [7:0] g [0:64];
        logic [7:0] r;
        int deg;
        for (int j = 0; j <= 64; j++) g[j] = 8'h00;
        g[0] = 8'h01;
        deg  = 0;
        for (int k = 1; k <= npar / 2; k++) begin
            for (int s = 0; s < 2; s++) begin
                r = (s == 0) ? rs_gf_pow(k) : rs_gf_pow(255 - k);
                for (int j = deg + 1; j >= 1; j--) g[j] = g[j-1] ^ rs_gf_mul(g[j], r);
                g[0] = rs_gf_mul(g[0], r);
                deg++;
            end
        end
        return g[idx];
    endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
// Constant multiplier y = a * C over GF(256).
// The first level precomputes C*a^b for each input bit at elaboration.
// The second level XORs the selected columns, so only XOR gates remain.
module rs_gf_cmul
    import rs_pkg::*;
#(
    parameter logic [7:0] C = 8'h01
) (
    input  logic [7:0] a,
    output logic [7:0] y
);
    logic [7:0] terms [8];

    for (genvar b = 0; b < 8; b++) begin : g_col
        localparam logic [7:0] COL = rs_gf_mul(C, 8'(1 << b));
        assign terms[b] = a[b] ? COL : 8'h00;
    end

    // Sum the selected columns.
    always_comb begin
        y = 8'h00;
        for (int b = 0; b < 8; b++) y = y ^ terms[b];
    end
endmodule

// File: rtl/rs_seq.sv
// Packet position tracker: opens a codeword on a start strobe, counts the
// accepted slots and marks the parity phase. Assumes K+NPAR > 1.
module rs_seq #(
    parameter int K    = 188,
    parameter int NPAR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    output logic take,
    output logic start,
    output logic par_ph
);
    localparam int N  = K + NPAR;
    localparam int PW = $clog2(N);
    localparam logic [PW-1:0] K_L    = PW'(K);
    localparam logic [PW-1:0] LAST_L = PW'(N - 1);

    logic          active;
    logic [PW-1:0] pos;

    assign start  = in_valid && in_sop;
    assign take   = in_valid && (in_sop || active);
    assign par_ph = take && !in_sop && (pos >= K_L);

    // Advance the slot counter on every accepted slot; close after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos    <= '0;
        end else if (start) begin
            active <= 1'b1;
            pos    <= PW'(1);
        end else if (take) begin
            if (pos == LAST_L) begin
                active <= 1'b0;
                pos    <= '0;
            end else begin
                pos <= pos + PW'(1);
            end
        end
    end

    // R3
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST_L);
    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> (active && pos == PW'(1)));
    // R9
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && in_valid && !in_sop) |=> !active);
endmodule

// File: rtl/rs_parity_lfsr.sv
// Division register for the parity remainder. Taps i and NPAR-i use the same
// coefficient, so only NPAR/2+1 constant multipliers are built.
// Assumes NPAR is even. Feedback is masked during the parity phase.
module rs_parity_lfsr
    import rs_pkg::*;
#(
    parameter int NPAR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       clear,
    input  logic       par_ph,
    input  logic [7:0] din,
    output logic [7:0] p_top
);
    localparam int HALF = NPAR / 2;

    logic [7:0] pr   [NPAR];
    logic [7:0] prod [HALF+1];
    logic [7:0] fb;

    assign p_top = pr[NPAR-1];
    assign fb    = par_ph ? 8'h00 : (din ^ (clear ? 8'h00 : pr[NPAR-1]));

    for (genvar k = 0; k <= HALF; k++) begin : g_mul
        rs_gf_cmul #(.C(rs_gen_coef(NPAR, k))) mul_i (.a(fb), .y(prod[k]));
    end

    for (genvar i = 0; i < NPAR; i++) begin : g_stage
        localparam int TK = (i <= HALF) ? i : NPAR - i;
        logic [7:0] prev;
        if (i == 0) begin : g_first
            assign prev = 8'h00;
        end else begin : g_rest
            assign prev = clear ? 8'h00 : pr[i-1];
        end
        // Shift one stage and add the shared tap product.
        always_ff @(posedge clk) begin
            if (!rst_n)    pr[i] <= 8'h00;
            else if (take) pr[i] <= prev ^ prod[TK];
        end
    end

    // R10
    parity_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && par_ph) |=> (pr[0] == 8'h00));
endmodule

// File: rtl/rs_outer_enc.sv
// Systematic shortened Reed-Solomon encoder: K data bytes pass through, then
// NPAR parity bytes follow on the next NPAR valid slots. Outputs are registered.
module rs_outer_enc
    import rs_pkg::*;
#(
    parameter int K    = RS_K,
    parameter int NPAR = RS_NPAR
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic       out_sop,
    output logic       out_par,
    output logic [7:0] out_byte
);
    logic       take;
    logic       start;
    logic       par_ph;
    logic [7:0] p_top;

    rs_seq #(.K(K), .NPAR(NPAR)) seq_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .take(take), .start(start), .par_ph(par_ph)
    );

    rs_parity_lfsr #(.NPAR(NPAR)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .take(take), .clear(start),
        .par_ph(par_ph), .din(in_byte), .p_top(p_top)
    );

    // Register the output byte and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_par   <= 1'b0;
            out_byte  <= 8'h00;
        end else begin
            out_valid <= take;
            out_sop   <= start;
            out_par   <= par_ph;
            out_byte  <= par_ph ? p_top : in_byte;
        end
    end

    // R7
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R6
    sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> (out_valid && !out_par));
    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_par) |-> (out_byte == $past(in_byte)));
endmodule

// File: tb/rs_outer_enc_tb_top.sv
// Bench: packets of distinct shapes; each codeword is checked by its syndromes.
module rs_outer_enc_tb_top;
    localparam int K = 188;
    localparam int P = 16;
    localparam int N = K + P;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid, out_sop, out_par;
    logic [7:0] out_byte;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] data [N];
    logic [7:0] cw   [N];

    always #2.5 clk = ~clk;

    rs_outer_enc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_byte(in_byte), .out_valid(out_valid), .out_sop(out_sop),
        .out_par(out_par), .out_byte(out_byte)
    );

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= s;
            s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1D : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [7:0] fpow(input int e);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < e; i++) r = fmul(r, 8'h02);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One slot: drive at negedge, sample outputs at the next negedge.
    task automatic step(input bit v, input bit s, input logic [7:0] d);
        in_valid = v; in_sop = s; in_byte = d;
        @(negedge clk);
    endtask

    // Send n slots of the packet held in data[]; gaps add idle slots.
    task automatic send(input int n, input bit gaps, input bit junk);
        int bad_d = 0, bad_f = 0, ea = 0, ee = 0;
        for (int j = 0; j < n; j++) begin
            if (gaps && (j % 7 == 3)) begin
                step(1'b0, 1'b0, 8'hA5);
                check(!out_valid, "R7", out_valid, 0);
            end
            step(1'b1, j == 0, (j < K) ? data[j] : (junk ? 8'($urandom) : 8'h00));
            cw[j] = out_byte;
            if (!(out_valid && out_sop == (j == 0) && out_par == (j >= K))) bad_f++;
            if (j < K && out_byte != data[j]) begin
                if (bad_d == 0) begin ea = out_byte; ee = data[j]; end
                bad_d++;
            end
        end
        in_valid = 1'b0; in_sop = 1'b0;
        check(bad_d == 0, "R2", ea, ee);
        check(bad_f == 0, "R3/R6 flags", bad_f, 0);
    endtask

    task automatic check_syn(input string req);
        int bad = 0;
        for (int k = 1; k <= P / 2; k++) begin
            for (int t = 0; t < 2; t++) begin
                logic [7:0] a = fpow(t == 0 ? k : 255 - k);
                logic [7:0] s = 8'h00;
                for (int j = 0; j < N; j++) s = fmul(s, a) ^ cw[j];
                if (s != 8'h00) bad++;
            end
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !out_sop && !out_par, "R1", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_sop && !out_par, "R1", out_valid, 0);

        // R5 all-zero packet
        for (int j = 0; j < K; j++) data[j] = 8'h00;
        send(N, 1'b0, 1'b0);
        begin
            int nz = 0;
            for (int j = K; j < N; j++) if (cw[j] != 8'h00) nz++;
            check(nz == 0, "R5", nz, 0);
        end
        check_syn("R4 zero");

        // R4 single non-zero byte at several positions
        foreach (data[pp]) if (pp < 0) data[pp] = 8'h00;
        for (int c = 0; c < 4; c++) begin
            int pos = (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 94 : 187;
            for (int j = 0; j < K; j++) data[j] = 8'h00;
            data[pos] = 8'h01 << c;
            send(N, 1'b0, 1'b0);
            check_syn("R4 single");
        end

        // R4/R7/R10 random packets, some with gaps and junk in parity slots
        for (int r = 0; r < 6; r++) begin
            for (int j = 0; j < K; j++) data[j] = 8'($urandom);
            send(N, r[0], r[1]);
            check_syn(r[1] ? "R10" : "R4 random");
        end

        // R8 abort in data phase, then full packet
        for (int j = 0; j < K; j++) data[j] = 8'($urandom);
        send(50, 1'b0, 1'b0);
        for (int j = 0; j < K; j++) data[j] = 8'($urandom);
        send(N, 1'b0, 1'b0);
        check_syn("R8 data-phase abort");

        // R8 abort in parity phase, then full packet
        for (int j = 0; j < K; j++) data[j] = 8'($urandom);
        send(195, 1'b0, 1'b1);
        for (int j = 0; j < K; j++) data[j] = 8'($urandom);
        send(N, 1'b1, 1'b0);
        check_syn("R8 parity-phase abort");

        // R9 stray valid bytes with no codeword open
        for (int j = 0; j < 5; j++) begin
            step(1'b1, 1'b0, 8'h3C);
            check(!out_valid, "R9", out_valid, 0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check(!out_valid, "R7", out_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule